// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits beside the write-load path of a byte-wide non-volatile memory. It observes every decoded write load (address, data and a one-cycle load strobe) together with a pulse from the byte-load timer that marks the end of a page-load window. From that traffic it recognises two command sequences. The three-byte lock/unlock sequence turns protection on and authorises the page load that follows it. The six-byte release sequence turns protection off. Bytes that the sequencer consumes as command steps never reach the page buffer.

The protection flag models a non-volatile bit. It starts cleared, as delivered from the factory, and the reset input does not touch it, so it survives power cycling. While the flag is set, a page load is allowed to commit only if the unlock sequence opened its window. The authorisation lasts until the window closes, that is until the byte-load timeout starts the program cycle. For each load the block reports whether that byte may enter the page buffer. It also reports whether writes are currently permitted and whether protection is on.

The sequence matcher listens only at the start of a page window, before any data byte of that window has been accepted. A command step is one load whose address and data match the expected pair. The pairs are data 0xAA at address 0x1555, data 0x55 at address 0x0AAA, and a final byte at address 0x1555.

Top module: `swp_seq`

## Requirements
- R1: After the first reset, prot_on is 0 and wr_permit is 1, and a data load (one whose address/data pair is not the expected command step) is accepted (wr_accept high in the load's cycle).
- R2: The loads 0xAA@0x1555, 0x55@0x0AAA, 0xA0@0x1555, taken in order in one window, are not accepted. prot_on and wr_permit are both 1 from the cycle after the third load, whether or not data follows.
- R3: While prot_on is 1 and no unlock has opened the current window, wr_permit is 0 and every data load is rejected.
- R4: After an unlock, data loads in the same window are accepted. A blc_timeout pulse ends the authorisation, and from the next cycle wr_permit is 0 and data is rejected again.
- R5: The six loads 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 are not accepted. They clear prot_on from the cycle after the sixth, after which data loads are accepted without a prefix.
- R6: A load that does not match the expected next step returns the matcher to idle and is handled as data. The exception is 0xAA@0x1555, which restarts the sequence as its first step.
- R7: A blc_timeout pulse in the middle of a sequence abandons it. A later final step is then handled as data, and prot_on is unchanged.
- R8: Deasserting rst_n clears a partial sequence and any authorisation but leaves prot_on unchanged.
- R9: Once a data byte has been accepted in the current window, loads matching command steps are ordinary data until blc_timeout.
- R10: wr_accept is combinational on the current load. prot_on and wr_permit change only at the clock edge that takes the completing load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of sequence and authorisation state |
| ld_valid | input | 1 | One-cycle write-load strobe |
| ld_addr | input | 13 | Address of the write load |
| ld_data | input | 8 | Data of the write load |
| blc_timeout | input | 1 | Byte-load window closed; program cycle starts |
| wr_accept | output | 1 | Current load may enter the page buffer |
| wr_permit | output | 1 | Data writes currently permitted |
| prot_on | output | 1 | Protection flag |

## Verification
The bench targets several corner cases, each of which catches a specific defect.
- A design that stored command bytes would raise wr_accept on the unlock steps.
- A design that failed to reset its matcher on a wrong step or on a timeout would lock the part after an interrupted sequence.
- A design that kept authorisation past the window end would let a second, unprefixed page through under protection.
- A design that reset the flag along with rst_n would drop protection at the reset pulse.
- A design whose matcher kept listening after data began would turn a page containing the command bytes into an accidental lock.

// File: rtl/swp_pkg.sv
package swp_pkg;
  parameter int ADDR_W = 13;
  parameter int DATA_W = 8;

  localparam logic [ADDR_W-1:0] CA_HI = 13'h1555;
  localparam logic [ADDR_W-1:0] CA_LO = 13'h0AAA;
  localparam logic [DATA_W-1:0] CD_LEAD  = 8'hAA;
  localparam logic [DATA_W-1:0] CD_ECHO  = 8'h55;
  localparam logic [DATA_W-1:0] CD_LOCK  = 8'hA0;
  localparam logic [DATA_W-1:0] CD_ERASE = 8'h80;
  localparam logic [DATA_W-1:0] CD_FREE  = 8'h20;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LEAD, SQ_ECHO, SQ_ERASE, SQ_LEAD2, SQ_ECHO2
  } seq_e;

  typedef struct packed {
    seq_e nxt;
    logic cmd;
    logic unl;
    logic dis;
  } step_t;

  function automatic logic pair_is(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                                   logic [ADDR_W-1:0] ea, logic [DATA_W-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // Restart rule: a mismatch falls back to idle unless it is itself a lead step.
  function automatic step_t restart(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    step_t s;
    s = '{nxt: SQ_IDLE, cmd: 1'b0, unl: 1'b0, dis: 1'b0};
    if (pair_is(a, d, CA_HI, CD_LEAD)) begin
      s.nxt = SQ_LEAD;
      s.cmd = 1'b1;
    end
    return s;
  endfunction

  function automatic step_t seq_step(seq_e cur, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    step_t s;
    s = restart(a, d);
    case (cur)
      SQ_LEAD:  if (pair_is(a, d, CA_LO, CD_ECHO)) s = '{nxt: SQ_ECHO, cmd: 1'b1, unl: 1'b0, dis: 1'b0};
      SQ_ECHO: begin
        if (pair_is(a, d, CA_HI, CD_LOCK))       s = '{nxt: SQ_IDLE, cmd: 1'b1, unl: 1'b1, dis: 1'b0};
        else if (pair_is(a, d, CA_HI, CD_ERASE)) s = '{nxt: SQ_ERASE, cmd: 1'b1, unl: 1'b0, dis: 1'b0};
      end
      SQ_ERASE: if (pair_is(a, d, CA_HI, CD_LEAD)) s = '{nxt: SQ_LEAD2, cmd: 1'b1, unl: 1'b0, dis: 1'b0};
      SQ_LEAD2: if (pair_is(a, d, CA_LO, CD_ECHO)) s = '{nxt: SQ_ECHO2, cmd: 1'b1, unl: 1'b0, dis: 1'b0};
      SQ_ECHO2: if (pair_is(a, d, CA_HI, CD_FREE)) s = '{nxt: SQ_IDLE, cmd: 1'b1, unl: 1'b0, dis: 1'b1};
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/swp_matcher.sv
module swp_matcher
  import swp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              listen,
  input  logic              abort,
  output logic              cmd_hit,
  output logic              unlock_done,
  output logic              disable_done,
  output logic              idle
);
  seq_e  state_q, state_eff, state_d;
  step_t step;
  logic  take;

  assign state_eff = abort ? SQ_IDLE : state_q;
  assign take      = ld_valid && listen;
  assign step      = seq_step(state_eff, ld_addr, ld_data);

  assign cmd_hit      = take && step.cmd;
  assign unlock_done  = take && step.unl;
  assign disable_done = take && step.dis;
  assign idle         = (state_q == SQ_IDLE);

  always_comb begin
    state_d = state_eff;
    if (take) state_d = step.nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  // R7: a timeout with no load leaves the matcher idle
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !ld_valid |=> idle);
  // R6: a load that is not a command step leaves the matcher idle
  a_r6_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cmd_hit |=> idle);
endmodule

// File: rtl/swp_guard.sv
module swp_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo,
  input  logic ld_valid,
  input  logic cmd_hit,
  input  logic unlock_done,
  input  logic disable_done,
  output logic listen,
  output logic wr_accept,
  output logic wr_permit,
  output logic prot_on
);
  // Non-volatile flag: factory value via initialiser, untouched by rst_n.
  logic prot_q = 1'b0;
  logic auth_q, open_q;
  logic auth_eff, open_eff;

  assign auth_eff  = auth_q && !tmo;
  assign open_eff  = open_q && !tmo;
  assign listen    = !auth_eff && !open_eff;
  assign wr_accept = ld_valid && !cmd_hit && (!prot_q || auth_eff);
  assign wr_permit = !prot_q || auth_q;
  assign prot_on   = prot_q;

  always_ff @(posedge clk) begin
    if (unlock_done)       prot_q <= 1'b1;
    else if (disable_done) prot_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auth_q <= 1'b0;
      open_q <= 1'b0;
    end else begin
      auth_q <= auth_eff || unlock_done;
      open_q <= open_eff || wr_accept;
    end
  end

  a_r2_unlock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_done |=> prot_on && wr_permit);
  a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    disable_done |=> !prot_on);
  a_r3_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_permit |-> !wr_accept);
  a_r4_auth_ends: assert property (@(posedge clk) disable iff (!rst_n)
    tmo && !ld_valid && prot_on |=> !wr_permit);
  a_r8_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock_done && !disable_done |=> $stable(prot_on));
endmodule

// File: rtl/swp_seq.sv
module swp_seq
  import swp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              blc_timeout,
  output logic              wr_accept,
  output logic              wr_permit,
  output logic              prot_on
);
  logic listen, cmd_hit, unlock_done, disable_done, m_idle;

  swp_matcher u_match (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .listen(listen), .abort(blc_timeout),
    .cmd_hit(cmd_hit), .unlock_done(unlock_done),
    .disable_done(disable_done), .idle(m_idle)
  );

  swp_guard u_guard (
    .clk(clk), .rst_n(rst_n), .tmo(blc_timeout), .ld_valid(ld_valid),
    .cmd_hit(cmd_hit), .unlock_done(unlock_done), .disable_done(disable_done),
    .listen(listen), .wr_accept(wr_accept), .wr_permit(wr_permit),
    .prot_on(prot_on)
  );

  // R2/R5: a consumed command step never reaches the page buffer
  a_r2_cmd_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |-> !wr_accept);
  // R9: the matcher is silent once a window holds data
  a_r9_silent_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    !listen |-> !cmd_hit);
endmodule

// File: tb/swp_seq_test.sv
module swp_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [12:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic blc_timeout = 1'b0;
  logic wr_accept, wr_permit, prot_on;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swp_seq uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .blc_timeout(blc_timeout), .wr_accept(wr_accept),
    .wr_permit(wr_permit), .prot_on(prot_on)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // One load for one cycle; wr_accept sampled mid-cycle (combinational).
  task automatic load(logic [12:0] a, logic [7:0] d, logic exp_acc, string tag);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    #1 chk(tag, wr_accept, exp_acc);
    @(posedge clk); #1 ld_valid = 1'b0;
  endtask

  task automatic close_window();
    @(negedge clk); blc_timeout = 1'b1;
    @(posedge clk); #1 blc_timeout = 1'b0;
  endtask

  task automatic status(logic exp_p, logic exp_w, string tag);
    @(negedge clk);
    chk({tag, " prot_on"}, prot_on, exp_p);
    chk({tag, " wr_permit"}, wr_permit, exp_w);
  endtask

  task automatic t_r1_shipped();
    status(1'b0, 1'b1, "R1 initial");
    load(13'h0100, 8'h12, 1'b1, "R1 data accepted");
    close_window();
  endtask

  task automatic t_r9_page_data();
    load(13'h0200, 8'h01, 1'b1, "R9 first data");
    load(13'h1555, 8'hAA, 1'b1, "R9 AA as data");
    load(13'h0AAA, 8'h55, 1'b1, "R9 55 as data");
    load(13'h1555, 8'hA0, 1'b1, "R9 A0 as data");
    status(1'b0, 1'b1, "R9 no lock");
    close_window();
  endtask

  task automatic t_r6_mismatch();
    load(13'h1555, 8'hAA, 1'b0, "R6 lead");
    load(13'h0AAA, 8'h55, 1'b0, "R6 echo");
    load(13'h1555, 8'h33, 1'b1, "R6 wrong byte is data");
    status(1'b0, 1'b1, "R6 after miss");
    close_window();
    load(13'h1555, 8'hAA, 1'b0, "R6 lead");
    load(13'h1555, 8'hAA, 1'b0, "R6 restart on lead");
    load(13'h0AAA, 8'h55, 1'b0, "R6 echo after restart");
    load(13'h0010, 8'h44, 1'b1, "R6 wrong final is data");
    status(1'b0, 1'b1, "R6 after restart miss");
    close_window();
  endtask

  task automatic t_r7_timeout_abort();
    load(13'h1555, 8'hAA, 1'b0, "R7 lead");
    load(13'h0AAA, 8'h55, 1'b0, "R7 echo");
    close_window();
    load(13'h1555, 8'hA0, 1'b1, "R7 final after timeout is data");
    status(1'b0, 1'b1, "R7 no lock");
    close_window();
  endtask

  task automatic t_r2_lock();
    load(13'h1555, 8'hAA, 1'b0, "R2 lead not stored");
    load(13'h0AAA, 8'h55, 1'b0, "R2 echo not stored");
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 13'h1555; ld_data = 8'hA0;
    #1;
    chk("R2 lock byte not stored", wr_accept, 1'b0);
    chk("R10 prot_on before edge", prot_on, 1'b0);
    @(posedge clk); #1 ld_valid = 1'b0;
    status(1'b1, 1'b1, "R2 locked, no data needed");
    close_window();
    status(1'b1, 1'b0, "R4 window closed");
  endtask

  task automatic t_r3_blocked();
    load(13'h0300, 8'h5A, 1'b0, "R3 unprefixed rejected");
    status(1'b1, 1'b0, "R3 still blocked");
    close_window();
  endtask

  task automatic t_r4_auth_page();
    load(13'h1555, 8'hAA, 1'b0, "R4 lead");
    load(13'h0AAA, 8'h55, 1'b0, "R4 echo");
    load(13'h1555, 8'hA0, 1'b0, "R4 unlock");
    load(13'h0400, 8'h11, 1'b1, "R4 data 1 accepted");
    load(13'h0401, 8'h22, 1'b1, "R4 data 2 accepted");
    close_window();
    status(1'b1, 1'b0, "R4 auth ended");
    load(13'h0402, 8'h33, 1'b0, "R4 next page rejected");
    close_window();
  endtask

  task automatic t_r8_reset();
    load(13'h1555, 8'hAA, 1'b0, "R8 lead");
    load(13'h0AAA, 8'h55, 1'b0, "R8 echo");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    status(1'b1, 1'b0, "R8 flag kept over reset");
    load(13'h1555, 8'hA0, 1'b0, "R8 partial sequence cleared");
    status(1'b1, 1'b0, "R8 still locked");
    close_window();
  endtask

  task automatic t_r5_release();
    load(13'h1555, 8'hAA, 1'b0, "R5 step1");
    load(13'h0AAA, 8'h55, 1'b0, "R5 step2");
    load(13'h1555, 8'h80, 1'b0, "R5 step3");
    load(13'h1555, 8'hAA, 1'b0, "R5 step4");
    load(13'h0AAA, 8'h55, 1'b0, "R5 step5");
    load(13'h1555, 8'h20, 1'b0, "R5 step6");
    status(1'b0, 1'b1, "R5 released");
    close_window();
    load(13'h0500, 8'h77, 1'b1, "R5 data without prefix");
    close_window();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_r1_shipped();
    t_r9_page_data();
    t_r6_mismatch();
    t_r7_timeout_abort();
    t_r2_lock();
    t_r3_blocked();
    t_r4_auth_page();
    t_r8_reset();
    t_r5_release();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule